// File: doc/BRIEF.md
# Two-Line Shared-Function GPIO Controller

This block runs two bidirectional pads. A 16-bit GPIO control word holds, for each line, a direction bit and a level bit. The bit-to-line mapping is crossed: the higher bit of each pair belongs to line 0. A line set as an output drives its stored level. A line set as an input returns its synchronized pad state in the level position of the same word when the word is read.

Each line can also carry a data-ready indication or an alarm indication. The enable, line select and active polarity for these come from control registers outside this block. When more than one function claims the same line, a fixed order decides what drives it. A set direction bit in the GPIO word always wins. Data-ready comes next and alarm comes last. A line that nothing claims is released to high impedance. The per-line output, output-enable and input signals connect straight to a tri-state pad cell.

Top module: `gpio2_pins`

## Requirements
- R1: After reset the control word reads 0x0000, and both padOe bits and both padOut bits are 0.
- R2: Word bit 9 sets the direction of line 0 and bit 8 sets the direction of line 1. A 1 makes the line a GPIO output (padOe high), and a write shows in rdData and on the pads in the cycle after the write edge.
- R3: Word bit 1 is the output level of line 0 and bit 0 is the output level of line 1. Writing 0x0202 drives line 0 high with padOe = 2'b01.
- R4: A line whose direction bit is 0 reads its pad state (line 0 in bit 1, line 1 in bit 0) through a two-stage synchronizer. A pad change made between edges shows in rdData after the second rising edge and not after the first.
- R5: A line whose direction bit is 1 reads back its stored level in its level bit.
- R6: Word bits 15:10 and 7:2 always read 0, and writing 1s to them changes neither rdData nor the pads.
- R7: When a line's direction bit is 1, that line drives its GPIO level even if data-ready or alarm also select it.
- R8: When a line is not a GPIO output and both data-ready and alarm select it, the data-ready level drives the line.
- R9: When a line is claimed by neither GPIO nor data-ready, and the alarm function is enabled and selects it, the alarm level drives the line with padOe high.
- R10: The data-ready and alarm pad levels equal their source signal when the matching active-high input is 1, and its inverse when it is 0.
- R11: A line that no function claims has padOe = 0 and padOut = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| wrEn | input | 1 | Write strobe for the GPIO control word |
| wrData | input | 16 | Value to write into the control word |
| rdData | output | 16 | Control word readback, including input pin states |
| drdyOn | input | 1 | Data-ready routing to a pin is enabled |
| drdySel | input | 1 | Line that carries data-ready |
| drdyHigh | input | 1 | Data-ready is active high when 1 |
| drdyIn | input | 1 | Data-ready source signal |
| alarmOn | input | 1 | Alarm routing to a pin is enabled |
| alarmSel | input | 1 | Line that carries the alarm |
| alarmHigh | input | 1 | Alarm is active high when 1 |
| alarmIn | input | 1 | Alarm source signal |
| padIn | input | 2 | Pad input levels, index = line |
| padOut | output | 2 | Pad output levels, index = line |
| padOe | output | 2 | Pad output enables, index = line |

## Verification
The assertions take for granted that the data-ready and alarm configuration inputs, and their source signals, are already synchronous to clk. They also assume reset is asserted before the first edge, so the stored word and the synchronizer hold known values. The stimulus changes every input, padIn included, only at falling edges. A pad level therefore crosses the synchronizer in a known number of edges, and each combinational pad output is observed one nanosecond after the inputs settle, well clear of the next rising edge.

// File: rtl/gpio2_pkg.sv
package gpio2_pkg;

  localparam int LINES   = 2;
  localparam int REG_W   = 16;
  localparam int DIR_LSB = 8;
  localparam int LVL_LSB = 0;
  localparam int SEL_W   = (LINES > 1) ? $clog2(LINES) : 1;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_GPIO  = 2'd1,
    OWN_DRDY  = 2'd2,
    OWN_ALARM = 2'd3
  } owner_e;

  typedef struct packed {
    logic                    load;
    logic [LINES-1:0]        dirData;
    logic [LINES-1:0]        lvlData;
    owner_e [LINES-1:0]      owner;
  } strobe_t;

  // Crossed mapping: line 0 sits at the higher bit of each pair.
  function automatic int dirBit(input int line);
    return DIR_LSB + (LINES - 1 - line);
  endfunction

  function automatic int lvlBit(input int line);
    return LVL_LSB + (LINES - 1 - line);
  endfunction

endpackage

// File: rtl/gpio2_ctrl.sv
module gpio2_ctrl
  import gpio2_pkg::*;
(
  input  logic               wrEn,
  input  logic [REG_W-1:0]   wrData,
  input  logic [LINES-1:0]   dirQ,
  input  logic               drdyOn,
  input  logic [SEL_W-1:0]   drdySel,
  input  logic               alarmOn,
  input  logic [SEL_W-1:0]   alarmSel,
  output strobe_t            strobe
);

  logic [LINES-1:0] dirPick;
  logic [LINES-1:0] lvlPick;
  owner_e [LINES-1:0] ownerPick;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    localparam int DB = dirBit(i);
    localparam int LB = lvlBit(i);

    logic drdyClaim;
    logic alarmClaim;

    assign dirPick[i]  = wrData[DB];
    assign lvlPick[i]  = wrData[LB];
    assign drdyClaim   = drdyOn  && (drdySel  == SEL_W'(i));
    assign alarmClaim  = alarmOn && (alarmSel == SEL_W'(i));

    always_comb begin
      if (dirQ[i])         ownerPick[i] = OWN_GPIO;
      else if (drdyClaim)  ownerPick[i] = OWN_DRDY;
      else if (alarmClaim) ownerPick[i] = OWN_ALARM;
      else                 ownerPick[i] = OWN_NONE;
    end
  end

  always_comb begin
    strobe.load    = wrEn;
    strobe.dirData = dirPick;
    strobe.lvlData = lvlPick;
    strobe.owner   = ownerPick;
  end

endmodule

// File: rtl/gpio2_dpath.sv
module gpio2_dpath
  import gpio2_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  strobe_t            strobe,
  input  logic               drdyOn,
  input  logic [SEL_W-1:0]   drdySel,
  input  logic               drdyHigh,
  input  logic               drdyIn,
  input  logic               alarmHigh,
  input  logic               alarmIn,
  input  logic [LINES-1:0]   padIn,
  output logic [LINES-1:0]   padOut,
  output logic [LINES-1:0]   padOe,
  output logic [LINES-1:0]   dirQ,
  output logic [REG_W-1:0]   rdData
);

  localparam int STAGES = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [LINES-1:0]              lvlQ;
  logic [STAGES-1:0][LINES-1:0]  syncQ;
  logic [LINES-1:0]              pinSync;
  logic                          drdyLevel;
  logic                          alarmLevel;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      dirQ <= '0;
      lvlQ <= '0;
    end else if (strobe.load) begin
      dirQ <= strobe.dirData;
      lvlQ <= strobe.lvlData;
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) syncQ <= '0;
    else     syncQ <= {syncQ[STAGES-2:0], padIn};
  end

  assign pinSync    = syncQ[STAGES-1];
  assign drdyLevel  = drdyHigh  ? drdyIn  : ~drdyIn;
  assign alarmLevel = alarmHigh ? alarmIn : ~alarmIn;

  for (genvar i = 0; i < LINES; i++) begin : g_pad
    always_comb begin
      unique case (strobe.owner[i])
        OWN_GPIO:  begin padOe[i] = 1'b1; padOut[i] = lvlQ[i];    end
        OWN_DRDY:  begin padOe[i] = 1'b1; padOut[i] = drdyLevel;  end
        OWN_ALARM: begin padOe[i] = 1'b1; padOut[i] = alarmLevel; end
        default:   begin padOe[i] = 1'b0; padOut[i] = 1'b0;       end
      endcase
    end

    AST_GPIO_WINS: assert property (@(posedge clk) disable iff (rst)
      dirQ[i] |-> (padOe[i] && padOut[i] == lvlQ[i])); // R7

    AST_DRDY_BEATS_ALARM: assert property (@(posedge clk) disable iff (rst)
      (!dirQ[i] && drdyOn && drdySel == SEL_W'(i)) |-> (padOe[i] && padOut[i] == drdyLevel)); // R8

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
      !padOe[i] |-> !padOut[i]); // R11
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < LINES; i++) begin
      rdData[dirBit(i)] = dirQ[i];
      rdData[lvlBit(i)] = dirQ[i] ? lvlQ[i] : pinSync[i];
    end
  end

  logic [REG_W-1:0] usedMask;
  always_comb begin
    usedMask = '0;
    for (int i = 0; i < LINES; i++) begin
      usedMask[dirBit(i)] = 1'b1;
      usedMask[lvlBit(i)] = 1'b1;
    end
  end

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rdData & ~usedMask) == '0); // R6

endmodule

// File: rtl/gpio2_pins.sv
module gpio2_pins
  import gpio2_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wrEn,
  input  logic [REG_W-1:0]   wrData,
  output logic [REG_W-1:0]   rdData,
  input  logic               drdyOn,
  input  logic [SEL_W-1:0]   drdySel,
  input  logic               drdyHigh,
  input  logic               drdyIn,
  input  logic               alarmOn,
  input  logic [SEL_W-1:0]   alarmSel,
  input  logic               alarmHigh,
  input  logic               alarmIn,
  input  logic [LINES-1:0]   padIn,
  output logic [LINES-1:0]   padOut,
  output logic [LINES-1:0]   padOe
);

  strobe_t          strobe;
  logic [LINES-1:0] dirQ;

  gpio2_ctrl u_ctrl (
    .wrEn     (wrEn),
    .wrData   (wrData),
    .dirQ     (dirQ),
    .drdyOn   (drdyOn),
    .drdySel  (drdySel),
    .alarmOn  (alarmOn),
    .alarmSel (alarmSel),
    .strobe   (strobe)
  );

  gpio2_dpath #(.SYNC_STAGES(SYNC_STAGES)) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .drdyOn    (drdyOn),
    .drdySel   (drdySel),
    .drdyHigh  (drdyHigh),
    .drdyIn    (drdyIn),
    .alarmHigh (alarmHigh),
    .alarmIn   (alarmIn),
    .padIn     (padIn),
    .padOut    (padOut),
    .padOe     (padOe),
    .dirQ      (dirQ),
    .rdData    (rdData)
  );

  AST_WRITE_DIR: assert property (@(posedge clk) disable iff (rst)
    wrEn |=> (rdData[DIR_LSB+1] == $past(wrData[DIR_LSB+1]) &&
              rdData[DIR_LSB]   == $past(wrData[DIR_LSB]))); // R2

  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wrEn |=> $stable(rdData[DIR_LSB+1:DIR_LSB])); // R2

  AST_DIR_DRIVES: assert property (@(posedge clk) disable iff (rst)
    rdData[DIR_LSB+1] |-> padOe[0]); // R2

endmodule

// File: tb/gpio2_pins_bench.sv
module gpio2_pins_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        drdyOn = 1'b0, drdySel = 1'b0, drdyHigh = 1'b1, drdyIn = 1'b0;
  logic        alarmOn = 1'b0, alarmSel = 1'b0, alarmHigh = 1'b1, alarmIn = 1'b0;
  logic [1:0]  padIn = 2'b00;
  logic [1:0]  padOut;
  logic [1:0]  padOe;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  gpio2_pins u_gpio2_pins (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .drdyOn(drdyOn), .drdySel(drdySel), .drdyHigh(drdyHigh), .drdyIn(drdyIn),
    .alarmOn(alarmOn), .alarmSel(alarmSel), .alarmHigh(alarmHigh), .alarmIn(alarmIn),
    .padIn(padIn), .padOut(padOut), .padOe(padOe)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got 0x%04h expected 0x%04h", req, got, exp);
    end
  endtask

  task automatic writeWord(input logic [15:0] value);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = value;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
    wrData = '0;
    #1;
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    check("R1 rdData", rdData, 16'h0000);
    check("R1 padOe", {14'd0, padOe}, 16'h0000);
    check("R1 padOut", {14'd0, padOut}, 16'h0000);
  endtask

  task automatic t_dirMap();
    writeWord(16'h0200);
    check("R2 line0 oe", {14'd0, padOe}, 16'h0001);
    check("R2 read", rdData, 16'h0200);
    writeWord(16'h0100);
    check("R2 line1 oe", {14'd0, padOe}, 16'h0002);
    check("R2 read line1", rdData, 16'h0100);
  endtask

  task automatic t_levels();
    writeWord(16'h0202);
    check("R3 oe", {14'd0, padOe}, 16'h0001);
    check("R3 out", {14'd0, padOut}, 16'h0001);
    check("R5 read 0202", rdData, 16'h0202);
    writeWord(16'h0301);
    check("R3 oe both", {14'd0, padOe}, 16'h0003);
    check("R3 out line1", {14'd0, padOut}, 16'h0002);
    check("R5 read 0301", rdData, 16'h0301);
  endtask

  task automatic t_inputRead();
    writeWord(16'h0000);
    check("R4 oe off", {14'd0, padOe}, 16'h0000);
    @(negedge clk);
    padIn = 2'b01;
    @(posedge clk);
    @(negedge clk); #1;
    check("R4 one edge", rdData, 16'h0000);
    @(posedge clk);
    @(negedge clk); #1;
    check("R4 line0 high", rdData, 16'h0002);
    padIn = 2'b10;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk); #1;
    check("R4 line1 high", rdData, 16'h0001);
    padIn = 2'b00;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk); #1;
    check("R4 both low", rdData, 16'h0000);
  endtask

  task automatic t_unused();
    writeWord(16'hFCFC);
    check("R6 read", rdData, 16'h0000);
    check("R6 oe", {14'd0, padOe}, 16'h0000);
    check("R6 out", {14'd0, padOut}, 16'h0000);
    writeWord(16'hFFFF);
    check("R6 read all", rdData, 16'h0303);
    check("R6 out all", {14'd0, padOut}, 16'h0003);
  endtask

  task automatic t_priority();
    writeWord(16'h0000);
    @(negedge clk);
    drdyOn = 1'b1; drdySel = 1'b0; drdyHigh = 1'b1; drdyIn = 1'b1;
    #1;
    check("R8 drdy alone oe", {14'd0, padOe}, 16'h0001);
    check("R8 drdy alone out", {14'd0, padOut}, 16'h0001);
    writeWord(16'h0200);
    check("R7 gpio oe", {14'd0, padOe}, 16'h0001);
    check("R7 gpio level", {14'd0, padOut}, 16'h0000);
    writeWord(16'h0000);
    @(negedge clk);
    alarmOn = 1'b1; alarmSel = 1'b0; alarmHigh = 1'b1; alarmIn = 1'b0;
    #1;
    check("R8 drdy over alarm", {14'd0, padOut}, 16'h0001);
    @(negedge clk);
    drdyOn = 1'b0;
    #1;
    check("R9 alarm oe", {14'd0, padOe}, 16'h0001);
    check("R9 alarm low", {14'd0, padOut}, 16'h0000);
    @(negedge clk);
    alarmIn = 1'b1;
    #1;
    check("R9 alarm high", {14'd0, padOut}, 16'h0001);
    @(negedge clk);
    alarmHigh = 1'b0;
    #1;
    check("R10 alarm inverted", {14'd0, padOut}, 16'h0000);
    @(negedge clk);
    alarmOn = 1'b0;
    drdyOn = 1'b1; drdySel = 1'b1; drdyHigh = 1'b0; drdyIn = 1'b1;
    #1;
    check("R10 drdy inverted oe", {14'd0, padOe}, 16'h0002);
    check("R10 drdy inverted out", {14'd0, padOut}, 16'h0000);
    @(negedge clk);
    drdyIn = 1'b0;
    #1;
    check("R10 drdy inverted high", {14'd0, padOut}, 16'h0002);
    writeWord(16'h0101);
    check("R7 line1 gpio", {14'd0, padOut}, 16'h0002);
    writeWord(16'h0100);
    check("R7 line1 gpio low", {14'd0, padOut}, 16'h0000);
    check("R7 line1 oe", {14'd0, padOe}, 16'h0002);
    writeWord(16'h0000);
    @(negedge clk);
    drdyOn = 1'b0;
    #1;
    check("R11 idle oe", {14'd0, padOe}, 16'h0000);
    check("R11 idle out", {14'd0, padOut}, 16'h0000);
  endtask

  initial begin
    #20000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    settle();
    t_reset();
    t_dirMap();
    t_levels();
    t_inputRead();
    t_unused();
    t_priority();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule